// File: doc/BRIEF.md
# Pulse-Additive PWM Generator

This block drives a bank of pulse-width outputs, by default sixteen, each set by an 8-bit duty value. The value is not matched against one 8-bit compare. Its high nibble sets the width of a short basic pulse, 16 ticks long, which repeats sixteen times in each 256-tick conversion period. Its low nibble adds that many single extra active ticks, spread evenly over those sixteen basic pulses. The output ripple therefore sits at the basic-pulse rate, sixteen times faster than the conversion rate, while the average still resolves to 1/256. Because of this split, a heavy low-pass filter is not needed to turn the outputs into analogue levels.

All channels share one time base. A prescaler produces a counting tick every 1, 2, 4, 8 or 16 clocks. An 8-bit period counter advances on each tick. Its low nibble gives the position inside a basic pulse and its high nibble gives the index of the basic pulse. The prescaler is a small state machine with five states: `PS_DIV1`, `PS_DIV2`, `PS_DIV4`, `PS_DIV8` and `PS_DIV16`. It has one kind of transition. At each terminal count (the tick), it moves to the state named by the select register. At any other clock it holds its state.

Software reaches the duty registers, the polarity bits and the prescaler select through a flat register port. Writes are synchronous and reads are combinational. Duty values are held in a shadow register and copied into each channel at the wrap of the period counter. Polarity bits act at once.

Top module: `pwm_pulse_add`

## Requirements
- R1: After reset every output is low and every mapped register reads 0. This covers the duty registers, the polarity bytes and the prescaler select.
- R2: Register map for the default of 16 channels:
  - addresses 0..15 are the duty registers;
  - address 16 holds polarity bits of channels 0..7 and address 17 holds those of channels 8..15, with bit n of the byte belonging to channel 8*byte+n;
  - address 18 holds the prescaler select in bits 2:0.
  Each mapped register reads back what was last written. Addresses 19..31 read 0, and writes to them change no register and no output.
- R3: In direct polarity, a channel with duty value D is high for exactly D ticks of every 256-tick conversion period. A value of 0 gives a constant low output, and 255 is the largest active count.
- R4: Let H be the high nibble and L the low nibble of the duty value. Let p be the counter's low nibble and k its high nibble. The output is active when p < H. It is also active when p == H and the 4-bit bit-reversal of k is less than L.
- R5: A duty write takes effect only from counter value 0 of the next conversion period. For the rest of the current period the output keeps following the old value.
- R6: Select values 0, 1, 2, 3 and 4 give a counting tick every 1, 2, 4, 8 and 16 clocks. Values 5 to 7 act as 16. The period counter advances by one per tick and wraps from 255 to 0.
- R7: A select change is taken up only at the prescaler's next terminal count. The interval that is in progress completes at the old ratio, and the counter neither skips nor repeats a value.
- R8: A polarity bit of 1 inverts its channel, so that the duty value sets the low time. The change acts from the clock after the write, without waiting for a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pwm_o | output | NUM_CH (16) | PWM outputs, one per channel |

## Verification
The bench covers the duty values at the edges of each nibble: 0x00, 0xFF, 0x0F, 0xF0, and single-bit values. A design that mis-handled the position compare at p == H, or that spread the extra ticks in index order instead of bit-reversed order, would break the per-position pattern check even where the total count happened to match. The bench also writes a duty value in the middle of a period. A design without the shadow register would switch at once and corrupt the remainder of that period. Last, the bench changes the prescaler select while a slow divide is running. A design that switched ratio immediately, or did not restart the divider count, would give a high run other than the 23 clocks that result from completing the current divide-by-16 interval.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NIB_W    = 4;
    localparam int DATA_W   = 2 * NIB_W;
    localparam int SEL_W    = 3;
    localparam int PS_CNT_W = 4;

    typedef enum logic [SEL_W-1:0] {
        PS_DIV1  = 3'd0,
        PS_DIV2  = 3'd1,
        PS_DIV4  = 3'd2,
        PS_DIV8  = 3'd3,
        PS_DIV16 = 3'd4
    } ps_state_e;

    function automatic logic [NIB_W-1:0] rev_nib(input logic [NIB_W-1:0] v);
        logic [NIB_W-1:0] r;
        for (int i = 0; i < NIB_W; i++) begin
            r[i] = v[NIB_W-1-i];
        end
        return r;
    endfunction

    function automatic ps_state_e sel_to_state(input logic [SEL_W-1:0] s);
        ps_state_e st;
        unique case (s)
            3'd0:    st = PS_DIV1;
            3'd1:    st = PS_DIV2;
            3'd2:    st = PS_DIV4;
            3'd3:    st = PS_DIV8;
            default: st = PS_DIV16;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    ps_state_e             state_q;
    ps_state_e             state_d;
    logic [PS_CNT_W-1:0]   div_cnt_q;
    logic [PS_CNT_W-1:0]   limit;

    // terminal count of the divider for the ratio currently in force
    always_comb begin
        unique case (state_q)
            PS_DIV1:  limit = PS_CNT_W'(0);
            PS_DIV2:  limit = PS_CNT_W'(1);
            PS_DIV4:  limit = PS_CNT_W'(3);
            PS_DIV8:  limit = PS_CNT_W'(7);
            PS_DIV16: limit = PS_CNT_W'(15);
            default:  limit = PS_CNT_W'(15);
        endcase
    end

    assign tick_o = (div_cnt_q == limit);

    // only a terminal count may move the ratio
    always_comb begin
        state_d = state_q;
        if (tick_o) begin
            state_d = sel_to_state(sel_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_DIV1;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
        end else if (tick_o) begin
            div_cnt_q <= '0;
        end else begin
            div_cnt_q <= div_cnt_q + 1'b1;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt_q <= limit);                                   // R6
    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(state_q));                         // R7

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              wrap_o
);

    logic [DATA_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (cnt_q == '1);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == DATA_W'($past(cnt_q) + 1'b1));     // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));                           // R7

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic [NUM_CH-1:0][DATA_W-1:0] duty_o,
    output logic [NUM_CH-1:0]             pol_o,
    output logic [SEL_W-1:0]              sel_o
);

    localparam int POL_BYTES = (NUM_CH + DATA_W - 1) / DATA_W;
    localparam int POL_ADDR  = NUM_CH;
    localparam int SEL_ADDR  = NUM_CH + POL_BYTES;

    logic [NUM_CH-1:0][DATA_W-1:0] duty_q;
    logic [NUM_CH-1:0]             pol_q;
    logic [SEL_W-1:0]              sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            pol_q  <= '0;
            sel_q  <= '0;
        end else if (we_i) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr_i == ADDR_W'(i)) begin
                    duty_q[i] <= wdata_i;
                end
                if (addr_i == ADDR_W'(POL_ADDR + i / DATA_W)) begin
                    pol_q[i] <= wdata_i[i % DATA_W];
                end
            end
            if (addr_i == ADDR_W'(SEL_ADDR)) begin
                sel_q <= wdata_i[SEL_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                rdata_o = duty_q[i];
            end
            if (addr_i == ADDR_W'(POL_ADDR + i / DATA_W)) begin
                rdata_o[i % DATA_W] = pol_q[i];
            end
        end
        if (addr_i == ADDR_W'(SEL_ADDR)) begin
            rdata_o = DATA_W'(sel_q);
        end
    end

    assign duty_o = duty_q;
    assign pol_o  = pol_q;
    assign sel_o  = sel_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] duty_i,
    input  logic              pol_i,
    output logic              pwm_o
);

    logic [DATA_W-1:0] active_q;
    logic [NIB_W-1:0]  pos;
    logic [NIB_W-1:0]  blk;
    logic [NIB_W-1:0]  width;
    logic [NIB_W-1:0]  extra;
    logic              on;

    // shadow copy loaded only as the period counter wraps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (wrap_i) begin
            active_q <= duty_i;
        end
    end

    assign pos   = cnt_i[NIB_W-1:0];
    assign blk   = cnt_i[DATA_W-1:NIB_W];
    assign width = active_q[DATA_W-1:NIB_W];
    assign extra = active_q[NIB_W-1:0];

    always_comb begin
        on = (pos < width);
        if ((pos == width) && (rev_nib(blk) < extra)) begin
            on = 1'b1;
        end
    end

    assign pwm_o = on ^ pol_i;

    AST_MIDPERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(active_q));                        // R5
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q == '0) |-> !on);                             // R3

endmodule

// File: rtl/pwm_pulse_add.sv
module pwm_pulse_add
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = $clog2(NUM_CH + (NUM_CH + 7) / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    logic                          tick;
    logic                          wrap;
    logic [DATA_W-1:0]             cnt;
    logic [SEL_W-1:0]              sel;
    logic [NUM_CH-1:0]             pol;
    logic [NUM_CH-1:0][DATA_W-1:0] duty;

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .duty_o  (duty),
        .pol_o   (pol),
        .sel_o   (sel)
    );

    pwm_prescaler u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .tick_o (tick)
    );

    pwm_period_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wrap_i (wrap),
            .cnt_i  (cnt),
            .duty_i (duty[c]),
            .pol_i  (pol[c]),
            .pwm_o  (pwm_o[c])
        );
    end

    AST_WRAP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> tick);                                        // R6

endmodule

// File: tb/tb_pwm_pulse_add.sv
module tb_pwm_pulse_add;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 16;
    localparam int AW         = 5;
    localparam int POL_A      = 16;
    localparam int SEL_A      = 18;

    localparam logic [7:0] VEC [0:2][0:15] = '{
        '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h01, 8'h10, 8'h80, 8'h7F,
          8'h55, 8'hAA, 8'h08, 8'h11, 8'hE7, 8'h3C, 8'h9B, 8'h02},
        '{8'hFE, 8'h0E, 8'h1F, 8'hEF, 8'h40, 8'h04, 8'hC3, 8'h66,
          8'h99, 8'h21, 8'h12, 8'hF1, 8'h8F, 8'h70, 8'h07, 8'hBD},
        '{8'h00, 8'h03, 8'h30, 8'h0C, 8'hC0, 8'h5A, 8'hA5, 8'h77,
          8'h88, 8'hDE, 8'h2B, 8'hB2, 8'h4E, 8'hE4, 8'h19, 8'h91}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            reg_we;
    logic [AW-1:0]   reg_addr;
    logic [7:0]      reg_wdata;
    logic [7:0]      reg_rdata;
    logic [NCH-1:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] exp_data [NCH];
    logic       exp_pol  [NCH];

    pwm_pulse_add dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_on(input logic [7:0] d, input int n);
        logic [3:0] p, k, r;
        p = 4'(n);
        k = 4'(n >> 4);
        r = {k[0], k[1], k[2], k[3]};
        return (p < d[7:4]) || ((p == d[7:4]) && (r < d[3:0]));
    endfunction

    task automatic reg_write(input int a, input logic [7:0] d);
        reg_we    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [7:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_period_start();
        @(negedge clk);
        while (cyc % 256 != 0) @(negedge clk);
    endtask

    // samples one whole period starting at counter value 0
    task automatic run_period();
        int  highs [NCH];
        bit  bad   [NCH];
        for (int c = 0; c < NCH; c++) begin
            highs[c] = 0;
            bad[c]   = 1'b0;
        end
        for (int n = 0; n < 256; n++) begin
            for (int c = 0; c < NCH; c++) begin
                if (pwm_o[c]) highs[c]++;
                if (pwm_o[c] !== (model_on(exp_data[c], n) ^ exp_pol[c])) bad[c] = 1'b1;
            end
            @(negedge clk);
        end
        for (int c = 0; c < NCH; c++) begin
            chk(!bad[c], "R4 per-tick pattern", c, exp_data[c]);
            if (exp_pol[c])
                chk(highs[c] == 256 - exp_data[c], "R8 inverted high count", highs[c], 256 - exp_data[c]);
            else
                chk(highs[c] == exp_data[c], "R3 high count", highs[c], exp_data[c]);
        end
    endtask

    task automatic measure_high(output int len);
        while (pwm_o[0]) @(negedge clk);
        while (!pwm_o[0]) @(negedge clk);
        len = 0;
        while (pwm_o[0]) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int len;
        bit ok;
        rst_n     = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        for (int c = 0; c < NCH; c++) begin
            exp_data[c] = 8'h00;
            exp_pol[c]  = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(pwm_o == '0, "R1 outputs in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(pwm_o == '0, "R1 outputs after reset", int'(pwm_o), 0);
        ok = 1'b1;
        for (int a = 0; a <= SEL_A; a++) begin
            reg_read(a, rd);
            if (rd != 8'h00) ok = 1'b0;
        end
        chk(ok, "R1 registers read zero", int'(ok), 1);

        // vector table walk
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                reg_write(c, VEC[s][c]);
                exp_data[c] = VEC[s][c];
            end
            if (s == 0) begin
                for (int c = 0; c < NCH; c++) begin
                    reg_read(c, rd);
                    chk(rd == VEC[s][c], "R2 duty readback", rd, VEC[s][c]);
                end
            end
            wait_period_start();
            run_period();
        end

        // R2 unmapped addresses
        @(negedge clk);
        reg_write(20, 8'hFF);
        reg_write(31, 8'hFF);
        reg_read(20, rd);
        chk(rd == 8'h00, "R2 unmapped reads zero", rd, 0);
        reg_read(0, rd);
        chk(rd == VEC[2][0], "R2 unmapped write ignored", rd, VEC[2][0]);
        reg_read(POL_A, rd);
        chk(rd == 8'h00, "R2 unmapped write left polarity", rd, 0);
        wait_period_start();
        run_period();

        // R8 polarity
        @(negedge clk);
        reg_write(POL_A, 8'h05);
        reg_write(POL_A + 1, 8'h80);
        exp_pol[0] = 1'b1; exp_pol[2] = 1'b1; exp_pol[15] = 1'b1;
        chk(pwm_o[0] == 1'b1, "R8 immediate inversion", pwm_o[0], 1);
        reg_read(POL_A + 1, rd);
        chk(rd == 8'h80, "R2 polarity readback", rd, 8'h80);
        wait_period_start();
        run_period();
        @(negedge clk);
        reg_write(POL_A, 8'h00);
        reg_write(POL_A + 1, 8'h00);
        exp_pol[0] = 1'b0; exp_pol[2] = 1'b0; exp_pol[15] = 1'b0;

        // R5 mid-period write is deferred
        reg_write(0, 8'h3C);
        wait_period_start();
        wait_period_start();
        repeat (100) @(negedge clk);
        reg_write(0, 8'hC3);
        ok = 1'b1;
        for (int n = 101; n < 256; n++) begin
            if (pwm_o[0] !== model_on(8'h3C, n)) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R5 old value kept to period end", int'(ok), 1);
        exp_data[0] = 8'hC3;
        run_period();

        // R6 divide ratios
        reg_write(0, 8'h80);
        wait_period_start();
        begin
            int sels [4] = '{1, 2, 3, 7};
            int divs [4] = '{2, 4, 8, 16};
            for (int i = 0; i < 4; i++) begin
                reg_write(SEL_A, 8'(sels[i]));
                measure_high(len);
                measure_high(len);
                chk(len == 8 * divs[i], "R6 basic pulse high clocks", len, 8 * divs[i]);
            end
        end
        reg_read(SEL_A, rd);
        chk(rd == 8'h07, "R2 select readback", rd, 7);

        // R7 select change completes the running interval
        while (pwm_o[0]) @(negedge clk);
        while (!pwm_o[0]) @(negedge clk);
        len = 1;
        reg_write(SEL_A, 8'h00);
        while (pwm_o[0]) begin
            len++;
            @(negedge clk);
        end
        chk(len == 23, "R7 switch at terminal count", len, 23);

        finish_run();
    end

endmodule